// File: doc/BRIEF.md
# Received Pause Transmit-Off Controller

This block holds the local transmitter off after the link partner sends a flow-control pause request, and lets it go again later. An upstream receive path has already parsed and validated each pause frame. It hands this block a one-cycle strobe together with the 16-bit pause time carried in the frame. A nonzero time starts a countdown measured in pause quanta, where one quantum is 512 bit times. The MAC supplies one tick per quantum. While the countdown runs, the transmit-off status output stays high.

The status drops when the countdown reaches zero, or when a pause frame arrives with a time of zero. A zero-time frame is a resume (XON) request, and the block counts such frames in a saturating counter that a synchronous clear input resets. When receive flow control is disabled, pause strobes have no effect: the frames then pass on as ordinary traffic. Disabling also drops any hold-off that is in progress.

Top module: `pause_holdoff`

## Requirements
- R1: After reset, `tx_off` is 0 and `xon_count` is 0.
- R2: A strobe on `pause_vld` with `fc_rx_en` high and a nonzero `pause_time` sets `tx_off` on the next cycle and loads the remaining count with `pause_time`.
- R3: While `tx_off` is high, each `quanta_tick` with no strobe in the same cycle lowers the remaining count by one. `tx_off` falls on the cycle after the tick that takes the count from 1 to 0, so a load of N is released after exactly N ticks.
- R4: A nonzero pause strobe that arrives while `tx_off` is high reloads the remaining count with the new value, and the countdown restarts from it.
- R5: A pause strobe with `fc_rx_en` high and `pause_time` equal to 0 clears `tx_off` on the next cycle and adds one to `xon_count`.
- R6: While `fc_rx_en` is low, pause strobes are ignored: `tx_off` does not rise and `xon_count` does not change. `fc_rx_en` low also forces `tx_off` to 0 on the next cycle.
- R7: `xon_count` saturates at 2^CW-1, and further XON frames leave it there.
- R8: `cnt_clr` high sets `xon_count` to 0 on the next cycle. It wins over an XON frame in the same cycle.
- R9: A pause strobe and a `quanta_tick` in the same cycle: the strobe takes effect and the tick is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fc_rx_en | input | 1 | Receive flow-control enable |
| pause_vld | input | 1 | One-cycle strobe for a validated pause frame |
| pause_time | input | TW (16) | Pause time field of the frame, in quanta |
| quanta_tick | input | 1 | One pulse per 512 bit times |
| cnt_clr | input | 1 | Synchronous clear of the XON counter |
| tx_off | output | 1 | Transmit hold-off status |
| xon_count | output | CW (16) | Saturating count of received XON frames |

## Verification
The embedded properties check every cycle that each decoded event moves the hold state as the requirements state. They check loading and XON release, the forced drop on disable, the per-tick decrement, that the status never rises without a pause event, that the status is never high with a zero count, and counter saturation and clear. The bench's scenarios are needed to show the end-to-end release timing after a given number of sparse ticks, reload in the middle of a countdown, and that strobes with the enable low leave both outputs untouched. They also cover the same-cycle collisions of a strobe with a tick and of a clear with an XON.

// File: rtl/pause_holdoff_pkg.sv
package pause_holdoff_pkg;
    typedef enum logic [1:0] {
        EV_NONE  = 2'd0,
        EV_PAUSE = 2'd1,
        EV_XON   = 2'd2,
        EV_OFF   = 2'd3
    } pause_ev_t;
endpackage

// File: rtl/pause_ev_decode.sv
module pause_ev_decode
    import pause_holdoff_pkg::*;
#(
    parameter int TW = 16
) (
    input  logic          fc_rx_en,
    input  logic          pause_vld,
    input  logic [TW-1:0] pause_time,
    output pause_ev_t     ev
);
    always_comb begin
        if (!fc_rx_en)
            ev = EV_OFF;
        else if (pause_vld && (pause_time != '0))
            ev = EV_PAUSE;
        else if (pause_vld)
            ev = EV_XON;
        else
            ev = EV_NONE;
    end
endmodule

// File: rtl/pause_countdown.sv
module pause_countdown
    import pause_holdoff_pkg::*;
#(
    parameter int TW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  pause_ev_t     ev,
    input  logic [TW-1:0] load_val,
    input  logic          tick,
    output logic          hold
);
    typedef struct packed {
        logic          hold;
        logic [TW-1:0] left;
    } cd_state_t;

    cd_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        unique case (ev)
            EV_OFF: begin
                st_d.hold = 1'b0;
                st_d.left = '0;
            end
            EV_PAUSE: begin
                st_d.hold = 1'b1;
                st_d.left = load_val;
            end
            EV_XON: begin
                st_d.hold = 1'b0;
                st_d.left = '0;
            end
            default: begin
                if (st_q.hold && tick) begin
                    st_d.left = st_q.left - 1'b1;
                    if (st_q.left == TW'(1))
                        st_d.hold = 1'b0;
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign hold = st_q.hold;

    p_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ev == EV_PAUSE |=> st_q.hold && st_q.left == $past(load_val));
    p_reload_r4: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.hold && ev == EV_PAUSE |=> st_q.left == $past(load_val));
    p_tick_dec_r3: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.hold && tick && ev == EV_NONE |=> st_q.left == $past(st_q.left) - 1'b1);
    p_nonzero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.hold |-> st_q.left != '0);
    p_xon_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ev == EV_XON |=> !st_q.hold);
    p_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ev == EV_OFF |=> !st_q.hold);
    p_no_spurious_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !st_q.hold && ev != EV_PAUSE |=> !st_q.hold);
endmodule

// File: rtl/xon_counter.sv
module xon_counter #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          inc,
    input  logic          clr,
    output logic [CW-1:0] count
);
    localparam logic [CW-1:0] CMAX = '1;

    typedef struct packed {
        logic [CW-1:0] cnt;
    } cnt_state_t;

    cnt_state_t cs_d, cs_q;

    always_comb begin
        cs_d = cs_q;
        if (clr)
            cs_d.cnt = '0;
        else if (inc && cs_q.cnt != CMAX)
            cs_d.cnt = cs_q.cnt + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            cs_q <= '0;
        else
            cs_q <= cs_d;
    end

    assign count = cs_q.cnt;

    p_sat_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cs_q.cnt == CMAX && !clr |=> cs_q.cnt == CMAX);
    p_clr_r8: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> cs_q.cnt == '0);
    p_inc_r5: assert property (@(posedge clk) disable iff (!rst_n)
        inc && !clr && cs_q.cnt != CMAX |=> cs_q.cnt == $past(cs_q.cnt) + 1'b1);
    p_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !inc && !clr |=> $stable(cs_q.cnt));
endmodule

// File: rtl/pause_holdoff.sv
module pause_holdoff
    import pause_holdoff_pkg::*;
#(
    parameter int TW = 16,
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          fc_rx_en,
    input  logic          pause_vld,
    input  logic [TW-1:0] pause_time,
    input  logic          quanta_tick,
    input  logic          cnt_clr,
    output logic          tx_off,
    output logic [CW-1:0] xon_count
);
    pause_ev_t ev;

    pause_ev_decode #(.TW(TW)) i_dec (
        .fc_rx_en  (fc_rx_en),
        .pause_vld (pause_vld),
        .pause_time(pause_time),
        .ev        (ev)
    );

    pause_countdown #(.TW(TW)) i_cd (
        .clk     (clk),
        .rst_n   (rst_n),
        .ev      (ev),
        .load_val(pause_time),
        .tick    (quanta_tick),
        .hold    (tx_off)
    );

    xon_counter #(.CW(CW)) i_cnt (
        .clk  (clk),
        .rst_n(rst_n),
        .inc  (ev == EV_XON),
        .clr  (cnt_clr),
        .count(xon_count)
    );

    p_disabled_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !fc_rx_en |=> !tx_off);
    p_dis_count_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !fc_rx_en && !cnt_clr |=> $stable(xon_count));
endmodule

// File: tb/test_pause_holdoff.sv
module test_pause_holdoff;
    localparam int TW = 16;
    localparam int CW = 4;
    localparam int CMAX = (1 << CW) - 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic fc_rx_en = 1'b0;
    logic pause_vld = 1'b0;
    logic [TW-1:0] pause_time = '0;
    logic quanta_tick = 1'b0;
    logic cnt_clr = 1'b0;
    logic tx_off;
    logic [CW-1:0] xon_count;

    int total = 0;
    int bad = 0;
    bit done = 0;
    string phase = "R1";

    int m_left = 0;
    bit m_hold = 0;
    int m_cnt = 0;

    always #2.5 clk = ~clk;

    pause_holdoff #(.TW(TW), .CW(CW)) i_pause_holdoff (
        .clk(clk), .rst_n(rst_n), .fc_rx_en(fc_rx_en), .pause_vld(pause_vld),
        .pause_time(pause_time), .quanta_tick(quanta_tick), .cnt_clr(cnt_clr),
        .tx_off(tx_off), .xon_count(xon_count)
    );

    // behavioural reference, updated on the same edge as the design
    always @(posedge clk) begin
        if (!rst_n) begin
            m_left = 0; m_hold = 0; m_cnt = 0;
        end else begin
            if (cnt_clr) m_cnt = 0;
            else if (fc_rx_en && pause_vld && pause_time == 0 && m_cnt < CMAX) m_cnt++;
            if (!fc_rx_en) begin
                m_hold = 0; m_left = 0;
            end else if (pause_vld) begin
                m_left = int'(pause_time);
                m_hold = (pause_time != 0);
            end else if (m_hold && quanta_tick) begin
                m_left--;
                if (m_left == 0) m_hold = 0;
            end
        end
    end

    // compare every cycle, away from the active edge
    always @(negedge clk) begin
        if (!done) begin
            total++;
            if (tx_off !== m_hold || int'(xon_count) != m_cnt) begin
                bad++;
                $display("FAIL %s: tx_off=%0b xon_count=%0d expected tx_off=%0b xon_count=%0d",
                         phase, tx_off, xon_count, m_hold, m_cnt);
            end
        end
    end

    task automatic step(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic frame(logic [TW-1:0] t);
        pause_vld = 1'b1; pause_time = t;
        step(1);
        pause_vld = 1'b0; pause_time = '0;
    endtask

    task automatic ticks(int n, int gap);
        for (int i = 0; i < n; i++) begin
            quanta_tick = 1'b1; step(1);
            quanta_tick = 1'b0; step(gap);
        end
    endtask

    task automatic expect_off(logic exp, string tag);
        total++;
        if (tx_off !== exp) begin
            bad++;
            $display("FAIL %s: tx_off=%0b expected %0b", tag, tx_off, exp);
        end
    endtask

    initial begin
        step(3);
        expect_off(1'b0, "R1");
        rst_n = 1'b1; fc_rx_en = 1'b1;
        step(2);

        phase = "R2"; frame(16'd5); expect_off(1'b1, "R2");
        phase = "R3"; ticks(4, 2); expect_off(1'b1, "R3");
        ticks(1, 2); expect_off(1'b0, "R3");
        ticks(3, 1); expect_off(1'b0, "R3");

        phase = "R4"; frame(16'd3); ticks(2, 1);
        frame(16'd4); ticks(3, 0); expect_off(1'b1, "R4");
        ticks(1, 1); expect_off(1'b0, "R4");

        phase = "R5"; frame(16'd200); ticks(2, 0);
        frame(16'd0); expect_off(1'b0, "R5");
        frame(16'd0); step(2);

        phase = "R9"; frame(16'd2);
        quanta_tick = 1'b1; pause_vld = 1'b1; pause_time = 16'd2; step(1);
        pause_vld = 1'b0; quanta_tick = 1'b0; step(1);
        ticks(1, 0); expect_off(1'b1, "R9");
        ticks(1, 0); expect_off(1'b0, "R9");

        phase = "R6"; frame(16'd50); fc_rx_en = 1'b0; step(1);
        expect_off(1'b0, "R6");
        frame(16'd9); frame(16'd0); ticks(2, 1); expect_off(1'b0, "R6");
        fc_rx_en = 1'b1; step(1);

        phase = "R7";
        for (int i = 0; i < CMAX + 4; i++) frame(16'd0);
        step(1);

        phase = "R8"; cnt_clr = 1'b1; pause_vld = 1'b1; pause_time = '0; step(1);
        cnt_clr = 1'b0; pause_vld = 1'b0; step(1);
        frame(16'd0); frame(16'd0); cnt_clr = 1'b1; step(1); cnt_clr = 1'b0;
        step(3);

        phase = "R1"; rst_n = 1'b0; frame(16'd7); step(1); expect_off(1'b0, "R1");
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            bad++; total++;
            $display("FAIL watchdog: run hung, expected completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule